// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This block is the multiply engine for a signed DSP extension. It picks a signed 16-bit half out of each of two 32-bit operands, multiplies the halves and returns the product. It can also add a 32-bit addend to that product, or add the product into a 64-bit accumulator. A second family of operations multiplies the full first operand by a selected half of the second. It keeps the middle 32 bits of the 48-bit product, which is the product scaled by 2^-16, and it can add a 32-bit addend to that.

Operations enter through a valid/ready request port and leave through a valid/ready result port. There is one register stage between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle, so a full-rate stream passes with one cycle of latency. When the consumer holds `out_ready` low, the result and its flag stay frozen and no new request is taken.

The 32-bit accumulate forms report signed overflow through `out_q_set`. That output is a set request for a sticky saturation flag held elsewhere. The sum itself wraps. The unit never clears that flag and touches no other condition flag. Register writeback and instruction decode are outside the block.

Top module: `hmac_unit`

## Requirements
- R1: `in_sel_m` = 0 selects `in_rm[15:0]` and 1 selects `in_rm[31:16]`; `in_sel_s` does the same for `in_rs`. Each selected half is treated as a signed 16-bit value.
- R2: Operation code 0 returns the signed 32-bit product of the two selected halves in `out_res[31:0]`, with `out_res[63:32]` = 0 and `out_q_set` = 0.
- R3: Operation code 1 returns (product + `in_rn`) mod 2^32 in `out_res[31:0]`, with the upper word 0. `out_q_set` is 1 exactly when this signed 32-bit addition overflows.
- R4: Operation code 2 returns bits 47:16 of the signed product of all of `in_rm` and the selected half of `in_rs`, with the upper word 0 and `out_q_set` = 0. `in_sel_m` has no effect.
- R5: Operation code 3 returns (the R4 value + `in_rn`) mod 2^32, with the upper word 0. `out_q_set` is 1 exactly when that signed addition overflows.
- R6: Operation code 4 returns ({`in_acc_hi`,`in_acc_lo`} + the 16×16 product sign-extended to 64 bits) mod 2^64 on all 64 bits. `out_q_set` is 0 even when the addition wraps.
- R7: Operation codes 5, 6 and 7 return 0 on all 64 bits with `out_q_set` = 0.
- R8: A request is accepted on a rising edge with `in_valid` and `in_ready` high. Its result appears with `out_valid` high after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_res` and `out_q_set` hold their values.
- R10: In reset and after it, until the first accepted request, `out_valid` = 0, `out_q_set` = 0 and `in_ready` = 1.
- R11: `out_q_set` is 0 in every cycle with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code (0 to 4 defined, 5 to 7 yield zero) |
| in_sel_m | input | 1 | Half select for the first multiplicand |
| in_sel_s | input | 1 | Half select for the second multiplicand |
| in_rm | input | 32 | First multiplicand word |
| in_rs | input | 32 | Second multiplicand word |
| in_rn | input | 32 | 32-bit addend |
| in_acc_hi | input | 32 | Upper word of the 64-bit accumulator |
| in_acc_lo | input | 32 | Lower word of the 64-bit accumulator |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 64 | Result; upper word zero for 32-bit forms |
| out_q_set | output | 1 | Set request for the sticky overflow flag |

## Verification
The bench aims at the most negative halfword squared, which a design that multiplies without sign extension would return as a large unsigned value. It drives accumulate overflow in both directions. A wrong overflow test would miss the negative case or flag a sum that merely crosses zero. It uses a scaled product that needs the upper bits of a negative operand, where a truncating multiplier would return garbage. It also uses a 64-bit accumulate with a carry from the low word and a wrap past the top, which must carry correctly and must not raise the overflow flag. The stall sequence checks that a held result stays frozen, that no second request slips in under back-pressure, and that a queued request follows in the very cycle the stall releases.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

  typedef enum logic [2:0] {
    OP_MUL16 = 3'd0,
    OP_MAC16 = 3'd1,
    OP_MULW  = 3'd2,
    OP_MACW  = 3'd3,
    OP_MACL  = 3'd4
  } hmac_op_e;

endpackage

// File: rtl/hmac_half_sel.sv
// Picks the low or high half of a word and sign-extends it to full width.
module hmac_half_sel #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word,
  input  logic          sel_hi,
  output logic [DW-1:0] ext
);
  localparam int HW = DW / 2;

  logic [HW-1:0] half;

  assign half = sel_hi ? word[DW-1:HW] : word[HW-1:0];
  assign ext  = {{(DW-HW){half[HW-1]}}, half};

endmodule

// File: rtl/hmac_core.sv
// Combinational product, scaled product, and the two accumulate adders.
module hmac_core
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  hmac_op_e        op,
  input  logic [DW-1:0]   hm,
  input  logic [DW-1:0]   hs,
  input  logic [DW-1:0]   rm,
  input  logic [DW-1:0]   rn,
  input  logic [2*DW-1:0] acc,
  output logic [2*DW-1:0] res,
  output logic            q
);
  localparam int HW = DW / 2;
  localparam int PW = DW + HW;

  logic signed [DW-1:0] hm_s, hs_s;
  logic [DW-1:0]        p16;
  logic [PW-1:0]        rm_x, hs_x, pw;
  logic [DW-1:0]        scaled;
  logic [DW-1:0]        addend, sum;
  logic                 ovf;
  logic [2*DW-1:0]      long_sum;
  logic                 unused_lo;

  assign hm_s = hm;
  assign hs_s = hs;
  // Both halves are sign-extended, so the true product fits in DW bits.
  assign p16  = hm_s * hs_s;

  // Wide form: sign-extend to PW bits; the low PW bits of the product are exact.
  assign rm_x   = {{HW{rm[DW-1]}}, rm};
  assign hs_x   = {{HW{hs[DW-1]}}, hs};
  assign pw     = rm_x * hs_x;
  assign scaled = pw[PW-1:HW];
  assign unused_lo = ^pw[HW-1:0];

  // One shared 32-bit adder for both narrow accumulate forms.
  assign addend = (op == OP_MACW) ? scaled : p16;
  assign sum    = addend + rn;
  assign ovf    = (addend[DW-1] == rn[DW-1]) && (sum[DW-1] != addend[DW-1]);

  assign long_sum = acc + {{DW{p16[DW-1]}}, p16};

  always_comb begin
    res = '0;
    q   = 1'b0;
    case (op)
      OP_MUL16: res = {{DW{1'b0}}, p16};
      OP_MAC16: begin res = {{DW{1'b0}}, sum}; q = ovf; end
      OP_MULW:  res = {{DW{1'b0}}, scaled};
      OP_MACW:  begin res = {{DW{1'b0}}, sum}; q = ovf; end
      OP_MACL:  res = long_sum;
      default:  begin res = '0; q = 1'b0; end
    endcase
  end

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_sel_m,
  input  logic            in_sel_s,
  input  logic [DW-1:0]   in_rm,
  input  logic [DW-1:0]   in_rs,
  input  logic [DW-1:0]   in_rn,
  input  logic [DW-1:0]   in_acc_hi,
  input  logic [DW-1:0]   in_acc_lo,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*DW-1:0] out_res,
  output logic            out_q_set
);
  localparam int NOPND = 2;

  logic [DW-1:0]   opnd_word [NOPND];
  logic            opnd_sel  [NOPND];
  logic [DW-1:0]   opnd_ext  [NOPND];
  hmac_op_e        op;
  logic [2*DW-1:0] core_res;
  logic            core_q;
  logic            take;

  logic            valid_r;
  logic [2*DW-1:0] res_r;
  logic            q_r;
  hmac_op_e        op_r;

  assign opnd_word[0] = in_rm;
  assign opnd_word[1] = in_rs;
  assign opnd_sel[0]  = in_sel_m;
  assign opnd_sel[1]  = in_sel_s;

  for (genvar g = 0; g < NOPND; g++) begin : g_sel
    hmac_half_sel #(.DW(DW)) u_sel (
      .word  (opnd_word[g]),
      .sel_hi(opnd_sel[g]),
      .ext   (opnd_ext[g])
    );
  end

  assign op = hmac_op_e'(in_op);

  hmac_core #(.DW(DW)) u_core (
    .op (op),
    .hm (opnd_ext[0]),
    .hs (opnd_ext[1]),
    .rm (in_rm),
    .rn (in_rn),
    .acc({in_acc_hi, in_acc_lo}),
    .res(core_res),
    .q  (core_q)
  );

  assign in_ready = !valid_r || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_r <= 1'b0;
      res_r   <= '0;
      q_r     <= 1'b0;
      op_r    <= OP_MUL16;
    end else begin
      if (take) begin
        valid_r <= 1'b1;
        res_r   <= core_res;
        q_r     <= core_q;
        op_r    <= op;
      end else if (out_ready) begin
        valid_r <= 1'b0;
      end
    end
  end

  assign out_valid = valid_r;
  assign out_res   = res_r;
  assign out_q_set = valid_r && q_r;

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res)) else $error("hold"); // R9
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_q_set)) else $error("hold q"); // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready) else $error("stall"); // R8
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) else $error("accept"); // R8
  AST_FLAG_ONLY_NARROW_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    out_q_set |-> (op_r == OP_MAC16 || op_r == OP_MACW)) else $error("q source"); // R3
  AST_UPPER_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_r != OP_MACL |-> out_res[2*DW-1:DW] == '0) else $error("upper"); // R2

endmodule

// File: tb/hmac_unit_test.sv
`timescale 1ns/1ps
module hmac_unit_test;

  localparam int NV = 15;
  localparam int VW = 3 + 2 + 5*32;

  // Fields: {op, sel_m, sel_s, rm, rs, rn, acc_hi, acc_lo}
  localparam logic [VW-1:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_FFFE, 32'h0, 32'h0, 32'h0},
    {3'd0, 1'b1, 1'b0, 32'h8000_1234, 32'h0000_7FFF, 32'h0, 32'h0, 32'h0},
    {3'd0, 1'b0, 1'b1, 32'hABCD_FFFF, 32'h1234_0000, 32'h0, 32'h0, 32'h0},
    {3'd1, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0, 32'h0},
    {3'd1, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_0064, 32'h0, 32'h0},
    {3'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0, 32'h0},
    {3'd2, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_0100, 32'h0, 32'h0, 32'h0},
    {3'd2, 1'b1, 1'b1, 32'hFFFF_0000, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0},
    {3'd3, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7000_0000, 32'h0, 32'h0},
    {3'd3, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0003, 32'h0000_000A, 32'h0, 32'h0},
    {3'd4, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 32'h0, 32'h0000_0000, 32'h0000_0000},
    {3'd4, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h0, 32'h0000_0001, 32'hFFFF_FFFF},
    {3'd4, 1'b1, 1'b1, 32'h7FFF_0000, 32'h7FFF_0000, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd5, 1'b1, 1'b1, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 32'h1, 32'h1},
    {3'd7, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0002, 32'h0000_0001, 32'h1, 32'h1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic        in_sel_m = 1'b0, in_sel_s = 1'b0;
  logic [31:0] in_rm = '0, in_rs = '0, in_rn = '0, in_acc_hi = '0, in_acc_lo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_res;
  logic        out_q_set;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hmac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel_m(in_sel_m), .in_sel_s(in_sel_s),
    .in_rm(in_rm), .in_rs(in_rs), .in_rn(in_rn),
    .in_acc_hi(in_acc_hi), .in_acc_lo(in_acc_lo),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_q_set(out_q_set)
  );

  // Reference model written from the requirements: returns {q, result}.
  function automatic logic [64:0] model(input logic [VW-1:0] v);
    logic [2:0]  op;
    logic        sm, ss;
    logic [31:0] rm, rs, rn, hi, lo;
    longint      hm, hs, p, w, s;
    logic [63:0] r;
    logic        q;
    {op, sm, ss, rm, rs, rn, hi, lo} = v;
    hm = longint'($signed(sm ? rm[31:16] : rm[15:0]));   // R1
    hs = longint'($signed(ss ? rs[31:16] : rs[15:0]));
    p  = hm * hs;
    w  = longint'($signed(rm)) * hs;
    r  = '0;
    q  = 1'b0;
    case (op)
      3'd0: r = {32'h0, p[31:0]};
      3'd1: begin
        s = p + longint'($signed(rn));
        r = {32'h0, s[31:0]};
        q = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd2: r = {32'h0, w[47:16]};
      3'd3: begin
        s = longint'($signed(w[47:16])) + longint'($signed(rn));
        r = {32'h0, s[31:0]};
        q = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd4: r = {hi, lo} + 64'(p);
      default: r = '0;
    endcase
    return {q, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    {in_op, in_sel_m, in_sel_s, in_rm, in_rs, in_rn, in_acc_hi, in_acc_lo} = v;
    in_valid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [64:0] e;
    logic [63:0] held;
    // R10: state during and just after reset
    repeat (3) @(negedge clk);
    check("R10 valid in reset", {63'h0, out_valid}, 64'h0);
    check("R10 q in reset", {63'h0, out_q_set}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", {63'h0, out_valid}, 64'h0);
    check("R10 ready after reset", {63'h0, in_ready}, 64'h1);

    // Vector table, one request per cycle.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      e = model(VECS[i]);
      check({tag_of(VECS[i][VW-1 -: 3]), " R8 valid"}, {63'h0, out_valid}, 64'h1);
      check({tag_of(VECS[i][VW-1 -: 3]), " result"}, out_res, e[63:0]);
      check({tag_of(VECS[i][VW-1 -: 3]), " q"}, {63'h0, out_q_set}, {63'h0, e[64]});
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drains", {63'h0, out_valid}, 64'h0);
    check("R11 q idle", {63'h0, out_q_set}, 64'h0);

    // Back-pressure: overflowing accumulate held under a stall.
    out_ready = 1'b0;
    drive(VECS[3]);
    @(negedge clk);
    e = model(VECS[3]);
    check("R8 stall ready low", {63'h0, in_ready}, 64'h0);
    held = out_res;
    check("R9 held result", held, e[63:0]);
    drive(VECS[6]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 result stable", out_res, held);
      check("R9 q stable", {63'h0, out_q_set}, 64'h1);
      check("R8 no accept", {63'h0, in_ready}, 64'h0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    e = model(VECS[6]);
    check("R8 queued follows", out_res, e[63:0]);
    check("R4 q after stall", {63'h0, out_q_set}, 64'h0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 q with valid low", {63'h0, out_q_set}, 64'h0);

    // R4: first select has no effect on the scaled form.
    drive({3'd2, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_0100, 32'h0, 32'h0, 32'h0});
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 sel_m ignored", out_res, 64'h0000_0000_0012_3456);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule